// File: doc/BRIEF.md
# Front-Panel Bus Takeover Controller

This block lets a manual operator console seize the shared address and data buses of a small computer. Activity on any console switch raises a request line. The request has no direct effect on the bus drivers. A small sequencer model sees it and accepts it only on a cycle flagged as a safe point, such as an instruction boundary. After accepting it, the sequencer stays in a holding loop and drives the acknowledge line for as long as the request stays up.

The acknowledge line decides who drives the buses. While it is high, the memory-side drivers are off and the console's address and data switch drivers are on. Handover in either direction inserts one idle clock, so the two sides never drive at the same time. When the console reads, its data drivers stay off and a register on the console LEDs captures the bus each clock. For board bring-up, a manual override can force acknowledge, but only while an enable jumper is fitted.

Top module: `fp_bus_handover`

## Requirements
- R1: After a synchronous reset, `dma_ack` is 0, `mem_drv_en` is 1, and `fp_addr_en` and `fp_data_en` are 0.
- R2: `sw_active` passes through two synchronizer flops. `dma_req` rises on the second clock edge after `sw_active` rises. The request alone never changes `mem_drv_en`, `fp_addr_en` or `fp_data_en`.
- R3: A pending request is accepted only on a clock edge where `safe_pt` is 1. While `safe_pt` stays 0, `dma_ack` stays 0 and the request keeps waiting.
- R4: Once accepted, `dma_ack` stays 1 while the synchronized request remains 1. It falls on the clock edge after `dma_req` falls.
- R5: The memory-side enable and any console enable (`fp_addr_en`, `fp_data_en`) are never 1 in the same cycle.
- R6: On takeover, `mem_drv_en` falls one clock after `dma_ack` rises, and `fp_addr_en` rises one clock after that. On release, `fp_addr_en` falls one clock after `dma_ack` falls, and `mem_drv_en` rises one clock after that.
- R7: `addr_out` equals `fp_addr_sw` while `fp_addr_en` is 1 and `mem_addr` otherwise. `data_out` equals `fp_data_sw` while `fp_data_en` is 1 and `mem_data` otherwise. The address is 22 bits and the data is 8 bits.
- R8: While the console owns the bus, `fp_data_en` follows `fp_write` with one clock of delay. While the console owns the bus and `fp_data_en` is 0, `fp_led` loads `bus_data_in` on every clock.
- R9: With `ovr_jumper` at 1, raising `ovr_toggle` sets `dma_ack` two clocks later, whatever the request or safe point. With `ovr_jumper` at 0, the toggle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_active | input | 1 | Asynchronous console switch activity level |
| safe_pt | input | 1 | Sequencer safe point strobe |
| ovr_toggle | input | 1 | Manual acknowledge override toggle |
| ovr_jumper | input | 1 | Enable jumper for the override toggle |
| fp_write | input | 1 | 1 = console writes data, 0 = console reads |
| fp_addr_sw | input | 22 | Console address switches |
| fp_data_sw | input | 8 | Console data switches |
| mem_addr | input | 22 | Memory-side address source |
| mem_data | input | 8 | Memory-side data source |
| bus_data_in | input | 8 | Sampled value of the shared data bus |
| dma_req | output | 1 | Synchronized request seen by the sequencer |
| dma_ack | output | 1 | Acknowledge: console owns the buses |
| mem_drv_en | output | 1 | Memory-side driver enable |
| fp_addr_en | output | 1 | Console address driver enable |
| fp_data_en | output | 1 | Console data driver enable |
| addr_out | output | 22 | Value presented to the address drivers |
| data_out | output | 8 | Value presented to the data drivers |
| fp_led | output | 8 | Data bus value latched for the console LEDs |

## Verification
A sequencer stuck in its holding loop shows up as `dma_ack` still high one clock after `dma_req` falls. A premature grant shows up as `dma_ack` rising on a cycle with no safe point. A wrong ownership register shows up as an overlap of `mem_drv_en` with a console enable, or as a missing idle cycle. Either error is visible within two clocks of the `dma_ack` edge. A wrong direction state shows up as `fp_data_en` or `fp_led` failing to track `fp_write` and `bus_data_in` one clock after they change.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_GAP  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOT = W * STAGES;

  logic [TOT-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[TOT-W-1:0], d};
      end
    end
  endgenerate

  assign q = sh[TOT-1 -: W];
endmodule

// File: rtl/fpd_seq.sv
module fpd_seq
  import fpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic safe_pt,
  output logic seq_ack
);
  sq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE;
    end else begin
      unique case (st)
        SQ_IDLE: if (req_s && safe_pt) st <= SQ_HOLD;
        SQ_HOLD: if (!req_s)           st <= SQ_GAP;
        SQ_GAP:                        st <= SQ_IDLE;
        default:                       st <= SQ_IDLE;
      endcase
    end
  end

  assign seq_ack = (st == SQ_HOLD);

  AST_NO_UNSAFE_GRANT: assert property (@(posedge clk) disable iff (rst)
    (st != SQ_HOLD && !safe_pt) |=> (st != SQ_HOLD)); // R3
  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_HOLD && req_s) |=> (st == SQ_HOLD)); // R4
  AST_LEAVE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_HOLD && !req_s) |=> (st != SQ_HOLD)); // R4
endmodule

// File: rtl/fpd_owner.sv
module fpd_owner #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_eff,
  input  logic              fp_write,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic              mem_own,
  output logic              fp_own,
  output logic              fp_den,
  output logic [DATA_W-1:0] led_q
);
  logic fp_next;

  assign fp_next = ack_eff && !mem_own;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_own <= 1'b1;
      fp_own  <= 1'b0;
      fp_den  <= 1'b0;
    end else begin
      mem_own <= !ack_eff && !fp_own;
      fp_own  <= fp_next;
      fp_den  <= fp_next && fp_write;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  led_q <= '0;
    else if (fp_own && !fp_den) led_q <= bus_data_in;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(mem_own && (fp_own || fp_den))); // R5
  AST_GAP_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(fp_own) |-> !mem_own); // R6
  AST_GAP_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(fp_own) |-> $past(!mem_own)); // R6
endmodule

// File: rtl/fp_bus_handover.sv
module fp_bus_handover #(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_active,
  input  logic              safe_pt,
  input  logic              ovr_toggle,
  input  logic              ovr_jumper,
  input  logic              fp_write,
  input  logic [ADDR_W-1:0] fp_addr_sw,
  input  logic [DATA_W-1:0] fp_data_sw,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic              dma_req,
  output logic              dma_ack,
  output logic              mem_drv_en,
  output logic              fp_addr_en,
  output logic              fp_data_en,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] fp_led
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn_q;
  logic              req_s;
  logic              ovr_s;
  logic              seq_ack;
  logic              ack_eff;

  assign raw_in = {ovr_jumper, ovr_toggle, sw_active};

  fpd_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_q)
  );

  assign req_s = syn_q[0];
  assign ovr_s = syn_q[1] && syn_q[2];

  fpd_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .req_s   (req_s),
    .safe_pt (safe_pt),
    .seq_ack (seq_ack)
  );

  assign ack_eff = seq_ack || ovr_s;

  fpd_owner #(.DATA_W(DATA_W)) u_own (
    .clk         (clk),
    .rst         (rst),
    .ack_eff     (ack_eff),
    .fp_write    (fp_write),
    .bus_data_in (bus_data_in),
    .mem_own     (mem_drv_en),
    .fp_own      (fp_addr_en),
    .fp_den      (fp_data_en),
    .led_q       (fp_led)
  );

  assign dma_req  = req_s;
  assign dma_ack  = ack_eff;
  assign addr_out = fp_addr_en ? fp_addr_sw : mem_addr;
  assign data_out = fp_data_en ? fp_data_sw : mem_data;

  AST_ACK_DROPS_MEM: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && !fp_addr_en) |=> !mem_drv_en); // R6
  AST_REQ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!dma_ack && !fp_addr_en) |=> !fp_addr_en); // R2
endmodule

// File: tb/sim_fp_bus_handover.sv
`timescale 1ns/1ps
module sim_fp_bus_handover;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_active = 1'b0, safe_pt = 1'b0, ovr_toggle = 1'b0, ovr_jumper = 1'b0;
  logic        fp_write = 1'b0;
  logic [21:0] fp_addr_sw = '0, mem_addr = '0, addr_out;
  logic [7:0]  fp_data_sw = '0, mem_data = '0, bus_data_in = '0, data_out, fp_led;
  logic        dma_req, dma_ack, mem_drv_en, fp_addr_en, fp_data_en;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fp_bus_handover u0 (
    .clk(clk), .rst(rst), .sw_active(sw_active), .safe_pt(safe_pt),
    .ovr_toggle(ovr_toggle), .ovr_jumper(ovr_jumper), .fp_write(fp_write),
    .fp_addr_sw(fp_addr_sw), .fp_data_sw(fp_data_sw), .mem_addr(mem_addr),
    .mem_data(mem_data), .bus_data_in(bus_data_in), .dma_req(dma_req),
    .dma_ack(dma_ack), .mem_drv_en(mem_drv_en), .fp_addr_en(fp_addr_en),
    .fp_data_en(fp_data_en), .addr_out(addr_out), .data_out(data_out),
    .fp_led(fp_led)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(3);
    chk("R1 ack", dma_ack, 0);
    chk("R1 mem en", mem_drv_en, 1);
    chk("R1 fp en", {fp_addr_en, fp_data_en}, 0);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_pending;
    safe_pt = 1'b0; sw_active = 1'b1;
    step(1); chk("R2 req after 1", dma_req, 0);
    step(1); chk("R2 req after 2", dma_req, 1);
    step(5);
    chk("R3 no grant", dma_ack, 0);
    chk("R2 mem keeps bus", mem_drv_en, 1);
    chk("R2 fp off", fp_addr_en, 0);
    safe_pt = 1'b1;
    step(1); chk("R3 grant on safe", dma_ack, 1);
    safe_pt = 1'b0;
    step(6); chk("R4 hold", dma_ack, 1);
    chk("R6 fp owns", fp_addr_en, 1);
    sw_active = 1'b0;
    step(1); chk("R4 still held", dma_ack, 1);
    step(1); chk("R4 req fell", dma_req, 0);
    chk("R4 ack until next edge", dma_ack, 1);
    step(1); chk("R4 ack fell", dma_ack, 0);
    step(3); chk("R6 mem back", mem_drv_en, 1);
  endtask

  task automatic t_handover;
    safe_pt = 1'b1; sw_active = 1'b1;
    step(3);
    chk("R4 ack rise", dma_ack, 1);
    chk("R6 mem still on", mem_drv_en, 1);
    step(1);
    chk("R6 mem off", mem_drv_en, 0);
    chk("R6 idle gap take", fp_addr_en, 0);
    step(1);
    chk("R6 fp on", fp_addr_en, 1);
    chk("R5 no overlap take", mem_drv_en, 0);
    sw_active = 1'b0;
    step(3);
    chk("R4 ack low", dma_ack, 0);
    chk("R6 fp still on", fp_addr_en, 1);
    step(1);
    chk("R6 fp off", fp_addr_en, 0);
    chk("R6 idle gap rel", mem_drv_en, 0);
    step(1);
    chk("R6 mem on", mem_drv_en, 1);
    safe_pt = 1'b0;
    step(2);
  endtask

  task automatic t_paths;
    fp_addr_sw = 22'h2A5F31; mem_addr = 22'h012345;
    fp_data_sw = 8'hC3; mem_data = 8'h3C;
    step(1);
    chk("R7 mem addr", addr_out, 32'h012345);
    chk("R7 mem data", data_out, 32'h3C);
    fp_write = 1'b1; safe_pt = 1'b1; sw_active = 1'b1;
    step(6);
    chk("R7 fp addr", addr_out, 32'h2A5F31);
    chk("R8 write en", fp_data_en, 1);
    chk("R7 fp data", data_out, 32'hC3);
    fp_write = 1'b0; bus_data_in = 8'h5A;
    step(1);
    chk("R8 read en off", fp_data_en, 0);
    chk("R8 no capture yet", fp_led, 0);
    step(1);
    chk("R8 led capture", fp_led, 32'h5A);
    bus_data_in = 8'hA7;
    step(1);
    chk("R8 led follows", fp_led, 32'hA7);
    sw_active = 1'b0; safe_pt = 1'b0;
    step(6);
    chk("R7 mem addr again", addr_out, 32'h012345);
    chk("R5 mem only", {mem_drv_en, fp_addr_en, fp_data_en}, 3'b100);
  endtask

  task automatic t_override;
    ovr_jumper = 1'b1; ovr_toggle = 1'b1;
    step(1); chk("R9 not yet", dma_ack, 0);
    step(1); chk("R9 forced", dma_ack, 1);
    step(2); chk("R9 fp owns", fp_addr_en, 1);
    ovr_toggle = 1'b0;
    step(6); chk("R9 release", {dma_ack, mem_drv_en}, 2'b01);
    ovr_jumper = 1'b0; ovr_toggle = 1'b1;
    step(6);
    chk("R9 ignored ack", dma_ack, 0);
    chk("R9 ignored mem", mem_drv_en, 1);
    ovr_toggle = 1'b0;
    step(2);
  endtask

  initial begin
    t_reset();
    t_pending();
    t_handover();
    t_paths();
    t_override();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule